// File: doc/BRIEF.md
# CAN bit timing sampler

This block splits each nominal CAN bit into time quanta and turns the raw receive line into one decided bit value per bit time, for the receive path of a CAN controller. A quantum enable, generated by an external prescaler, advances the block by one quantum. A configuration word supplies the length of the segment before the sample point, the length of the segment after it, and a mode bit. The mode bit selects either one sample at the sample point or a two-of-three majority over the last three quanta before it. Each bit starts with one synchronization quantum, then segment 1, then segment 2. The sample point is the end of segment 1.

The sampler starts in an idle state. It leaves that state on a hard sync, which is a recessive-to-dominant edge of the line seen between two enabled quanta. From then on it runs freely and does not resynchronize. Settings that encode a segment that is too short raise a configuration-error flag, and the sampler is held idle for as long as they remain.

The decided bit leaves the block as a stream: `smp_stb` is the valid qualifier for `smp_bit`. There is no ready input, because a CAN bus cannot be paused. The consumer must take every strobe in the clock cycle it is asserted, and `smp_bit` keeps its value until the next strobe. The other pins are plain control and status.

Top module: `can_bit_sampler`

## Requirements
- R1: The configuration word is decoded as follows. Bits 3:0 hold the segment 1 field, and the segment 1 length is the field value plus 1 quanta. Bits 6:4 hold the segment 2 field, and the segment 2 length is the field value plus 1 quanta. Bit 7 is the mode bit, where 0 selects single-sample and 1 selects three-sample. Bits 15:8 have no effect on any output.
- R2: `cfg_err` is a combinational output. It is 1 exactly when the segment 2 field is 0 (a length of 1) or the segment 1 field is below 3 (a length under 4).
- R3: While `cfg_err` is 1, no `smp_stb` or `bit_end` pulse occurs in the next cycle, and line edges have no effect. Once the error clears, the sampler stays idle until a hard sync.
- R4: When idle, the sampler starts only on an enabled quantum where the line is 0 and the line was 1 on the previous enabled quantum. That quantum is the synchronization quantum, index 0. Rising edges and a steady line leave it idle.
- R5: A bit lasts N = 1 + L1 + L2 quanta. `bit_end` pulses for the quantum with index N-1 and repeats every N quanta.
- R6: `smp_stb` pulses once per bit, for the quantum with index L1 (the last quantum of segment 1). It never coincides with `bit_end`.
- R7: In single-sample mode, `smp_bit` equals the line level at quantum L1.
- R8: In three-sample mode, `smp_bit` is the majority of the line levels at quanta L1-2, L1-1 and L1.
- R9: After a hard sync, further line edges do not move the quantum count.
- R10: State advances only on clocks where `tq_en` is 1, and the line is ignored on other clocks. `smp_stb` and `bit_end` are registered one-clock pulses in the clock after the enabled edge.
- R11: While reset is active, `smp_stb` and `bit_end` are 0, `smp_bit` is 1 (recessive), and the sampler is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tq_en | input | 1 | One-clock enable per time quantum |
| rx_in | input | 1 | Raw receive line (1 = recessive) |
| cfg_word | input | CFG_W | Mode bit and the two segment fields |
| smp_stb | output | 1 | Valid strobe for `smp_bit` |
| smp_bit | output | 1 | Decided bit value |
| bit_end | output | 1 | Pulse after the last quantum of a bit |
| cfg_err | output | 1 | Invalid segment setting, sampler held idle |

## Verification
The bench uses the default parameters: a 4-bit segment 1 field, a 3-bit segment 2 field and a 16-bit configuration word. At this size it can cover every one of the 91 valid segment pairs in both sampling modes, and every one of the 256 low-byte codes for the error flag. Each valid pair runs four bits after a hard sync. The line pattern is chosen so that single-sample and majority decisions differ, and mid-bit edges are injected. The upper byte and the quantum-enable spacing are varied across runs, which exercises the ignored bits and the gated advance.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/can_bt_cfg_decode.sv
module can_bt_cfg_decode #(
  parameter int CFG_W    = 16,
  parameter int SEG1_W   = 4,
  parameter int SEG2_W   = 3,
  parameter int SEG1_MIN = 4,
  parameter int SEG2_MIN = 2,
  localparam int LEN1_W  = SEG1_W + 1,
  localparam int LEN2_W  = SEG2_W + 1,
  localparam int MODE_POS = SEG1_W + SEG2_W
) (
  input  logic [CFG_W-1:0]  cfg_word,
  output logic              triple,
  output logic [LEN1_W-1:0] len1,
  output logic [LEN2_W-1:0] len2,
  output logic              err
);

  logic [SEG1_W-1:0] f1;
  logic [SEG2_W-1:0] f2;
  logic              cfg_hi_unused;

  assign f1     = cfg_word[SEG1_W-1:0];
  assign f2     = cfg_word[MODE_POS-1:SEG1_W];
  assign triple = cfg_word[MODE_POS];

  // upper bits carry no meaning
  assign cfg_hi_unused = ^cfg_word[CFG_W-1:MODE_POS+1];

  always_comb begin
    len1 = LEN1_W'(f1) + LEN1_W'(1);
    len2 = LEN2_W'(f2) + LEN2_W'(1);
    err  = (len1 < LEN1_W'(SEG1_MIN)) || (len2 < LEN2_W'(SEG2_MIN));
  end

endmodule

// File: rtl/can_bt_quantum_ctr.sv
module can_bt_quantum_ctr
  import can_bt_pkg::*;
#(
  parameter int LEN1_W = 5,
  parameter int LEN2_W = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tq_en,
  input  logic              rx_in,
  input  logic              hold,
  input  logic [LEN1_W-1:0] len1,
  input  logic [LEN2_W-1:0] len2,
  output logic              at_smp,
  output logic              bit_end
);

  run_state_e       state;
  logic [CNT_W-1:0] q;
  logic [CNT_W-1:0] last_q;
  logic             rx_prev;
  logic             fall;
  logic             proc;

  assign last_q = CNT_W'(len1) + CNT_W'(len2);
  assign fall   = rx_prev & ~rx_in;
  assign proc   = tq_en & ~hold & (state == ST_RUN);
  assign at_smp = proc & (q == CNT_W'(len1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_prev <= 1'b1;
    end else if (tq_en) begin
      rx_prev <= rx_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      q       <= '0;
      bit_end <= 1'b0;
    end else if (hold) begin
      state   <= ST_IDLE;
      q       <= '0;
      bit_end <= 1'b0;
    end else begin
      bit_end <= 1'b0;
      if (tq_en) begin
        unique case (state)
          ST_IDLE: begin
            if (fall) begin
              state <= ST_RUN;
              q     <= CNT_W'(1);
            end
          end
          ST_RUN: begin
            if (q >= last_q) begin
              q       <= '0;
              bit_end <= 1'b1;
            end else begin
              q <= q + CNT_W'(1);
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/can_bt_vote.sv
module can_bt_vote
  import can_bt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tq_en,
  input  logic rx_in,
  input  logic triple,
  input  logic at_smp,
  output logic smp_stb,
  output logic smp_bit
);

  logic [1:0] hist;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist    <= 2'b11;
      smp_stb <= 1'b0;
      smp_bit <= 1'b1;
    end else begin
      smp_stb <= 1'b0;
      if (tq_en) begin
        hist <= {hist[0], rx_in};
      end
      if (at_smp) begin
        smp_stb <= 1'b1;
        smp_bit <= triple ? maj3(hist[1], hist[0], rx_in) : rx_in;
      end
    end
  end

endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler #(
  parameter int CFG_W    = 16,
  parameter int SEG1_W   = 4,
  parameter int SEG2_W   = 3,
  parameter int SEG1_MIN = 4,
  parameter int SEG2_MIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_en,
  input  logic             rx_in,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             smp_stb,
  output logic             smp_bit,
  output logic             bit_end,
  output logic             cfg_err
);

  localparam int LEN1_W  = SEG1_W + 1;
  localparam int LEN2_W  = SEG2_W + 1;
  localparam int MAX_BIT = 1 + (1 << SEG1_W) + (1 << SEG2_W);
  localparam int CNT_W   = $clog2(MAX_BIT);

  logic              triple;
  logic [LEN1_W-1:0] len1;
  logic [LEN2_W-1:0] len2;
  logic              at_smp;

  can_bt_cfg_decode #(
    .CFG_W(CFG_W), .SEG1_W(SEG1_W), .SEG2_W(SEG2_W),
    .SEG1_MIN(SEG1_MIN), .SEG2_MIN(SEG2_MIN)
  ) u_dec (
    .cfg_word(cfg_word),
    .triple  (triple),
    .len1    (len1),
    .len2    (len2),
    .err     (cfg_err)
  );

  can_bt_quantum_ctr #(
    .LEN1_W(LEN1_W), .LEN2_W(LEN2_W), .CNT_W(CNT_W)
  ) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .tq_en  (tq_en),
    .rx_in  (rx_in),
    .hold   (cfg_err),
    .len1   (len1),
    .len2   (len2),
    .at_smp (at_smp),
    .bit_end(bit_end)
  );

  can_bt_vote u_vote (
    .clk    (clk),
    .rst_n  (rst_n),
    .tq_en  (tq_en),
    .rx_in  (rx_in),
    .triple (triple),
    .at_smp (at_smp),
    .smp_stb(smp_stb),
    .smp_bit(smp_bit)
  );

endmodule

// File: rtl/can_bit_sampler_chk.sv
module can_bit_sampler_chk (
  input logic clk,
  input logic rst_n,
  input logic tq_en,
  input logic cfg_err,
  input logic smp_stb,
  input logic bit_end
);

  logic [1:0] stb_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_err || bit_end) begin
      stb_cnt <= 2'd0;
    end else if (smp_stb && stb_cnt != 2'd3) begin
      stb_cnt <= stb_cnt + 2'd1;
    end
  end

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> (!smp_stb && !bit_end)); // R3
  AST_STB_ON_QUANTUM: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> $past(tq_en)); // R10
  AST_END_ON_QUANTUM: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> $past(tq_en)); // R10
  AST_STB_NOT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_stb && bit_end)); // R6
  AST_ONE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> (stb_cnt == 2'd1)); // R6
  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> !smp_stb); // R10

endmodule

bind can_bit_sampler can_bit_sampler_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tq_en  (tq_en),
  .cfg_err(cfg_err),
  .smp_stb(smp_stb),
  .bit_end(bit_end)
);

// File: tb/can_bit_sampler_bench.sv
module can_bit_sampler_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tq_en = 1'b0;
  logic        rx_in = 1'b1;
  logic [15:0] cfg_word = 16'h0023;
  logic        smp_stb, smp_bit, bit_end, cfg_err;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  can_bit_sampler u_can_bit_sampler (
    .clk(clk), .rst_n(rst_n), .tq_en(tq_en), .rx_in(rx_in),
    .cfg_word(cfg_word), .smp_stb(smp_stb), .smp_bit(smp_bit),
    .bit_end(bit_end), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic rx);
    tq_en = en;
    rx_in = rx;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic maj(input logic [2:0] v);
    return (v[2] & v[1]) | (v[2] & v[0]) | (v[1] & v[0]);
  endfunction

  // one hard-synced run of four bits for a valid setting
  task automatic run_cfg(input int s1f, input int s2f, input logic mode,
                         input logic [7:0] hi, input int gap);
    logic [2:0] vpat [4];
    int l1, l2, nq;
    logic rxv;
    vpat = '{3'b001, 3'b110, 3'b111, 3'b010};
    l1 = s1f + 1;
    l2 = s2f + 1;
    nq = 1 + l1 + l2;
    // error phase with a falling edge that must be ignored
    cfg_word = {hi, 8'h00};
    step(1'b1, 1'b1);
    check("R3 quiet while error", smp_stb + bit_end, 0);
    step(1'b1, 1'b0);
    check("R3 edge ignored while error", smp_stb + bit_end, 0);
    cfg_word = {hi, mode, 3'(s2f), 4'(s1f)};
    #1;
    check("R2 valid setting clears flag", cfg_err, 0);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b1);
      check("R4 idle without falling edge", smp_stb + bit_end, 0);
    end
    step(1'b1, 1'b0);
    check("R4 sync quantum", smp_stb + bit_end, 0);
    for (int a = 1; a < 4 * nq; a++) begin
      int q, k;
      q = a % nq;
      k = a / nq;
      if (q == l1 - 2)      rxv = vpat[k][2];
      else if (q == l1 - 1) rxv = vpat[k][1];
      else if (q == l1)     rxv = vpat[k][0];
      else                  rxv = (a % 3 != 0); // R9 mid-bit edges
      for (int g = 0; g < gap; g++) begin
        step(1'b0, ~rxv);
        check("R10 no pulse without enable", smp_stb + bit_end, 0);
      end
      step(1'b1, rxv);
      check("R6 sample strobe position", smp_stb, (q == l1) ? 1 : 0);
      check("R5,R9 bit end position", bit_end, (q == nq - 1) ? 1 : 0);
      if (q == l1) begin
        if (mode) check("R1,R8 majority value", smp_bit, maj(vpat[k]));
        else      check("R1,R7 single value", smp_bit, vpat[k][0]);
      end
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    check("R11 reset strobe", smp_stb, 0);
    check("R11 reset bit end", bit_end, 0);
    check("R11 reset bit value", smp_bit, 1);
    rst_n = 1'b1;
    step(1'b1, 1'b1);
    check("R11 idle after reset", smp_stb + bit_end, 0);

    // error flag over all low-byte codes with varied upper byte
    for (int c = 0; c < 256; c++) begin
      int e;
      cfg_word = {8'(c * 37 + 11), 8'(c)};
      e = ((c & 15) < 3 || ((c >> 4) & 7) == 0) ? 1 : 0;
      #1;
      check("R2,R1 error flag decode", cfg_err, e);
      step(1'b1, 1'b1);
    end

    // every valid pair in both modes
    for (int m = 0; m < 2; m++) begin
      for (int s1 = 3; s1 < 16; s1++) begin
        for (int s2 = 1; s2 < 8; s2++) begin
          run_cfg(s1, s2, m[0], 8'(s1 * 16 + s2 * 3 + m),
                  ((s1 + s2) % 5 == 0) ? 2 : 0);
        end
      end
    end

    summary();
    $finish;
  end

endmodule